// File: doc/BRIEF.md
# Power-Up Strap Capture and Frequency Code Selector

This block sits beside the output stage of a clock generator whose configuration straps share pins with clock outputs. While power-on reset is active, the shared pins are inputs and the block keeps their output drivers off. The first clock edge that sees the power-on-done indication stores the pin levels in a latch and turns the drivers on. The stored levels then stay fixed until the next power-on reset.

The straps hold a frequency select code and a mode bit. The mode bit picks desktop or mobile use for the power-management pins. At run time a register bit chooses where the frequency code comes from: the stored straps or a register field. The chosen code is registered, so a change of source gives one clean step at a clock edge. The block also offers the stored frequency bits in inverted form for serial readback, and a registered global tristate control driven by a register bit.

Top module: `strap_fsel`

## Requirements
- R1: While `rst_n` is low, `pin_oe` is all zeros, `fs_code` is 0, `out_hiz` is 0, `mode_desktop` is 0 and `strap_rb` is all ones.
- R2: Strap levels are captured at the first rising clock edge after reset where `por_done` is 1. At that same edge `pin_oe` becomes all ones, unless tristate is active. Before that edge `pin_oe` stays all zeros.
- R3: After capture, changes on `strap_in` or `por_done` do not alter `strap_rb` or `mode_desktop` until `rst_n` is asserted again.
- R4: With `cfg_sel_reg` = 0, `fs_code` equals the captured strap bits `strap_in[FS_W-1:0]` one clock after they are stored.
- R5: With `cfg_sel_reg` = 1, `fs_code` equals `cfg_code` as sampled on the previous rising edge.
- R6: `strap_rb` is the bitwise inverse of the captured `strap_in[FS_W-1:0]`.
- R7: `mode_desktop` is the captured level of `strap_in[FS_W]`, where 1 means desktop and 0 means mobile.
- R8: `out_hiz` follows `cfg_tristate` one clock later. While `out_hiz` is 1, `pin_oe` is all zeros. When `cfg_tristate` returns to 0, the enables come back on the next clock.
- R9: `fs_code` changes only at rising clock edges. A change of `cfg_code` or `cfg_sel_reg` between edges leaves it unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| por_done | input | 1 | Power-on sequence finished; triggers capture |
| strap_in | input | FS_W+1 | Sampled pin levels: frequency bits [FS_W-1:0], mode bit [FS_W] |
| cfg_sel_reg | input | 1 | Code source: 0 straps, 1 register field |
| cfg_code | input | FS_W | Register frequency field |
| cfg_tristate | input | 1 | 1 requests all outputs in high impedance |
| pin_oe | output | FS_W+1 | Output enables of the shared pins |
| fs_code | output | FS_W | Registered active frequency code |
| strap_rb | output | FS_W | Inverted captured frequency bits for readback |
| mode_desktop | output | 1 | Captured mode strap |
| out_hiz | output | 1 | Registered global tristate control |

## Verification
The bench builds the block with the default code width of four, which makes five shared pins. At that size every one of the 32 strap patterns gets a full power-on cycle, and under each pattern all 16 register codes are swept. The checks cover capture, freezing of the latch, mode decoding, readback inversion and both code sources, including a source switch between clock edges. Tristate entry and exit are exercised after every capture.

// File: rtl/strap_fsel.sv
module strap_fsel #(
  parameter int FS_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            por_done,
  input  logic [FS_W:0]   strap_in,
  input  logic            cfg_sel_reg,
  input  logic [FS_W-1:0] cfg_code,
  input  logic            cfg_tristate,
  output logic [FS_W:0]   pin_oe,
  output logic [FS_W-1:0] fs_code,
  output logic [FS_W-1:0] strap_rb,
  output logic            mode_desktop,
  output logic            out_hiz
);
  localparam int NPIN = FS_W + 1;

  logic            run_q;
  logic [NPIN-1:0] strap_q;
  logic            hiz_q;
  logic [FS_W-1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      strap_q <= '0;
    end else if (!run_q && por_done) begin
      run_q   <= 1'b1;
      strap_q <= strap_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hiz_q  <= 1'b0;
      code_q <= '0;
    end else begin
      hiz_q  <= cfg_tristate;
      code_q <= cfg_sel_reg ? cfg_code : strap_q[FS_W-1:0];
    end
  end

  assign pin_oe       = {NPIN{run_q & ~hiz_q}};
  assign fs_code      = code_q;
  assign strap_rb     = ~strap_q[FS_W-1:0];
  assign mode_desktop = strap_q[FS_W];
  assign out_hiz      = hiz_q;
endmodule

module strap_fsel_chk #(
  parameter int FS_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            por_done,
  input logic            run,
  input logic            cfg_sel_reg,
  input logic [FS_W-1:0] cfg_code,
  input logic [FS_W:0]   pin_oe,
  input logic [FS_W-1:0] fs_code,
  input logic [FS_W-1:0] strap_rb,
  input logic            mode_desktop,
  input logic            out_hiz
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (pin_oe == '0 && !out_hiz && fs_code == '0));

  a_r2_oe_needs_por: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $rose(run)) |-> $past(por_done));

  a_r2_oe_off_before_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> pin_oe == '0);

  a_r3_latch_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(run)) |-> ($stable(strap_rb) && $stable(mode_desktop)));

  a_r4_strap_source: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(cfg_sel_reg)) |-> fs_code == ~$past(strap_rb));

  a_r5_reg_source: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cfg_sel_reg)) |-> fs_code == $past(cfg_code));

  a_r8_hiz_kills_oe: assert property (@(posedge clk) disable iff (!rst_n)
    out_hiz |-> pin_oe == '0);
endmodule

bind strap_fsel strap_fsel_chk #(.FS_W(FS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .por_done(por_done), .run(run_q),
  .cfg_sel_reg(cfg_sel_reg), .cfg_code(cfg_code), .pin_oe(pin_oe),
  .fs_code(fs_code), .strap_rb(strap_rb), .mode_desktop(mode_desktop),
  .out_hiz(out_hiz)
);

// File: tb/tb_strap_fsel.sv
module tb_strap_fsel;
  localparam int FS_W = 4;
  localparam int NPIN = FS_W + 1;
  localparam time TCLK = 10ns;

  logic            clk = 1'b0;
  logic            rst_n, por_done, cfg_sel_reg, cfg_tristate;
  logic [FS_W:0]   strap_in;
  logic [FS_W-1:0] cfg_code;
  logic [FS_W:0]   pin_oe;
  logic [FS_W-1:0] fs_code, strap_rb;
  logic            mode_desktop, out_hiz;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  strap_fsel #(.FS_W(FS_W)) dut (
    .clk(clk), .rst_n(rst_n), .por_done(por_done), .strap_in(strap_in),
    .cfg_sel_reg(cfg_sel_reg), .cfg_code(cfg_code), .cfg_tristate(cfg_tristate),
    .pin_oe(pin_oe), .fs_code(fs_code), .strap_rb(strap_rb),
    .mode_desktop(mode_desktop), .out_hiz(out_hiz)
  );

  always #(TCLK/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic nedge(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; por_done = 0; cfg_sel_reg = 0; cfg_tristate = 0;
    strap_in = '0; cfg_code = '0;
    for (int s = 0; s < (1 << NPIN); s++) begin
      nedge(1);
      rst_n = 0; por_done = 0; cfg_sel_reg = 0; cfg_tristate = 0;
      strap_in = NPIN'(s); cfg_code = '1;
      nedge(2);
      // R1 reset state
      chk("R1 oe", 32'(pin_oe), 0);
      chk("R1 code", 32'(fs_code), 0);
      chk("R1 hiz", 32'(out_hiz), 0);
      chk("R1 mode", 32'(mode_desktop), 0);
      chk("R1 rb", 32'(strap_rb), 32'((1 << FS_W) - 1));
      rst_n = 1;
      nedge(2);
      chk("R2 oe before por", 32'(pin_oe), 0);
      por_done = 1;
      nedge(1);
      chk("R2 oe after capture", 32'(pin_oe), 32'((1 << NPIN) - 1));
      chk("R6 readback", 32'(strap_rb), 32'(~s & ((1 << FS_W) - 1)));
      chk("R7 mode", 32'(mode_desktop), 32'((s >> FS_W) & 1));
      nedge(1);
      chk("R4 strap code", 32'(fs_code), 32'(s & ((1 << FS_W) - 1)));
      strap_in = ~NPIN'(s); por_done = 0;
      nedge(2);
      por_done = 1;
      nedge(2);
      chk("R3 rb frozen", 32'(strap_rb), 32'(~s & ((1 << FS_W) - 1)));
      chk("R3 mode frozen", 32'(mode_desktop), 32'((s >> FS_W) & 1));
      chk("R4 code after strap change", 32'(fs_code), 32'(s & ((1 << FS_W) - 1)));
      cfg_sel_reg = 1;
      for (int c = 0; c < (1 << FS_W); c++) begin
        logic [FS_W-1:0] prev;
        prev = fs_code;
        cfg_code = FS_W'(c);
        #1;
        chk("R9 no change between edges", 32'(fs_code), 32'(prev));
        nedge(1);
        chk("R5 register code", 32'(fs_code), 32'(c));
      end
      cfg_sel_reg = 0;
      #1;
      chk("R9 source switch between edges", 32'(fs_code), 32'((1 << FS_W) - 1));
      nedge(1);
      chk("R4 back to straps", 32'(fs_code), 32'(s & ((1 << FS_W) - 1)));
      cfg_tristate = 1;
      nedge(1);
      chk("R8 hiz on", 32'(out_hiz), 1);
      chk("R8 oe off", 32'(pin_oe), 0);
      cfg_tristate = 0;
      nedge(1);
      chk("R8 hiz off", 32'(out_hiz), 0);
      chk("R8 oe back", 32'(pin_oe), 32'((1 << NPIN) - 1));
    end
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule